// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block checks a page chunk read from flash against its error-correcting code. For each 256-byte half it takes two 22-bit codes: the code computed over the data as it arrived, and the code that was stored with the data. It forms their difference, sorts the result into one of four outcomes, and for a single flipped data bit it reports the byte offset, the bit number and an XOR mask. A buffer manager applies the mask to the data.

In single mode only the low code lane is examined. In dual mode the chunk is 512 bytes. Lane 0 covers bytes 0 to 255 and lane 1 covers bytes 256 to 511. The lanes are examined in order. An error in an earlier lane stops the evaluation, and corrections from the lanes that are used are summed into a flip count. Results appear one clock after the input strobe and hold until the next strobe.

Top module: `ecc_syndrome_fix`

## Requirements
- R1: `valid_o` pulses high exactly one cycle after each cycle with `valid_i` high. All result outputs are registered on that strobe and hold their value while no new strobe arrives.
- R2: For a lane, the syndrome is calc XOR stored over 22 bits. The lane is clean when the syndrome is zero, or when either code is all zeros.
- R3: A lane whose syndrome has exactly one bit set is a code-field error. Status is 1 and no fix is enabled for that lane.
- R4: A lane is corrected (status 2) when the syndrome has exactly 11 bits set and (calc[10:0]^calc[21:11])^(stored[10:0]^stored[21:11]) equals 0x7FF. The byte offset is syndrome[10:3], the bit index is syndrome[2:0], and the lane mask is 1 shifted left by the bit index.
- R5: Any other lane syndrome is uncorrectable, with status 3.
- R6: Lane L uses code bits [22L+21:22L]. In the outputs it uses `fix_en_o[L]`, `fix_byte_o[8L+7:8L]`, `fix_bit_o[3L+2:3L]` and `fix_mask_o[8L+7:8L]`. Outputs for a lane without a fix are zero.
- R7: In dual mode the first lane in order (lane 0 first) with status 1 or 3 sets the overall status. The flip count is then 0, later lanes get no fix, and a fix found in an earlier lane stays enabled.
- R8: With no error, `flips_o` is the number of corrected lanes in use (0 to 2). Overall status is 2 if that number is nonzero and 0 otherwise.
- R9: In single mode (`dual_i`=0) the lane 1 codes are ignored and `fix_en_o[1]` is 0.
- R10: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Codes are valid this cycle |
| dual_i | input | 1 | 1: 512-byte chunk (both lanes), 0: 256-byte chunk |
| calc_i | input | 44 | Calculated codes, lane L at [22L+21:22L] |
| stored_i | input | 44 | Stored codes, same layout |
| valid_o | output | 1 | Result strobe |
| status_o | output | 2 | 0 clean, 1 code-field error, 2 corrected, 3 uncorrectable |
| flips_o | output | 2 | Number of corrected bits |
| fix_en_o | output | 2 | Per-lane fix enable |
| fix_byte_o | output | 16 | Per-lane failing byte offset within the lane |
| fix_bit_o | output | 6 | Per-lane failing bit index |
| fix_mask_o | output | 16 | Per-lane XOR mask for the failing byte |

## Verification
The bench uses the default parameters: an 8-bit byte index, a 3-bit bit index and two lanes. This exposes the full 0 to 255 offset range and both dual-mode lanes. The two-lane setup gives access to the ordering between lanes: an error in lane 0 that masks a fix in lane 1, and a fix in lane 0 that stays enabled when lane 1 fails. Syndromes are built as a pattern and its complement, which gives the exact 11-bit correctable form. Single and double bit flips of that form give near-misses that must be classed as uncorrectable.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_CODE_ERR = 2'd1,
    ST_FIXED    = 2'd2,
    ST_FATAL    = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
  parameter int W     = 22,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CNT_W'(vec_i[i]);
  end
endmodule

// File: rtl/ecc_lane_eval.sv
module ecc_lane_eval
  import ecc_pkg::*;
#(
  parameter int BYTE_IDX_W = 8,
  parameter int BIT_IDX_W  = 3,
  localparam int HALF_W    = BYTE_IDX_W + BIT_IDX_W,
  localparam int CODE_W    = 2 * HALF_W
) (
  input  logic [CODE_W-1:0]     calc_i,
  input  logic [CODE_W-1:0]     stored_i,
  output ecc_status_e           status_o,
  output logic [BYTE_IDX_W-1:0] byte_o,
  output logic [BIT_IDX_W-1:0]  bit_o
);
  localparam int CNT_W = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] syn;
  logic [CNT_W-1:0]  weight;
  logic [HALF_W-1:0] pair;

  assign syn  = calc_i ^ stored_i;
  assign pair = (calc_i[HALF_W-1:0] ^ calc_i[CODE_W-1:HALF_W]) ^
                (stored_i[HALF_W-1:0] ^ stored_i[CODE_W-1:HALF_W]);

  ecc_popcount #(.W(CODE_W)) u_pop (.vec_i(syn), .cnt_o(weight));

  always_comb begin
    byte_o = syn[HALF_W-1:BIT_IDX_W];
    bit_o  = syn[BIT_IDX_W-1:0];
    if (syn == '0 || calc_i == '0 || stored_i == '0)
      status_o = ST_CLEAN;
    else if (weight == CNT_W'(1))
      status_o = ST_CODE_ERR;
    else if (weight == CNT_W'(HALF_W) && pair == '1)
      status_o = ST_FIXED;
    else
      status_o = ST_FATAL;
  end
endmodule

// File: rtl/ecc_lane_merge.sv
module ecc_lane_merge
  import ecc_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int FLIPS_W = $clog2(LANES + 1)
) (
  input  logic                  dual_i,
  input  ecc_status_e           lane_st_i [LANES],
  output ecc_status_e           status_o,
  output logic [FLIPS_W-1:0]    flips_o,
  output logic [LANES-1:0]      fix_en_o
);
  logic [LANES-1:0] active;
  logic             stop;

  always_comb begin
    active    = dual_i ? '1 : LANES'(1);
    status_o  = ST_CLEAN;
    flips_o   = '0;
    fix_en_o  = '0;
    stop      = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (active[l] && !stop) begin
        if (lane_st_i[l] == ST_CODE_ERR || lane_st_i[l] == ST_FATAL) begin
          status_o = lane_st_i[l];
          stop     = 1'b1;
        end else if (lane_st_i[l] == ST_FIXED) begin
          fix_en_o[l] = 1'b1;
          flips_o     = flips_o + FLIPS_W'(1);
        end
      end
    end
    // earlier-lane fixes stay enabled on abort; count is dropped
    if (stop) flips_o = '0;
    else if (flips_o != '0) status_o = ST_FIXED;
  end
endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
  import ecc_pkg::*;
#(
  parameter int BYTE_IDX_W = 8,
  parameter int BIT_IDX_W  = 3,
  parameter int LANES      = 2,
  localparam int HALF_W    = BYTE_IDX_W + BIT_IDX_W,
  localparam int CODE_W    = 2 * HALF_W,
  localparam int MASK_W    = 1 << BIT_IDX_W,
  localparam int FLIPS_W   = $clog2(LANES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        dual_i,
  input  logic [LANES*CODE_W-1:0]     calc_i,
  input  logic [LANES*CODE_W-1:0]     stored_i,
  output logic                        valid_o,
  output logic [1:0]                  status_o,
  output logic [FLIPS_W-1:0]          flips_o,
  output logic [LANES-1:0]            fix_en_o,
  output logic [LANES*BYTE_IDX_W-1:0] fix_byte_o,
  output logic [LANES*BIT_IDX_W-1:0]  fix_bit_o,
  output logic [LANES*MASK_W-1:0]     fix_mask_o
);
  ecc_status_e             lane_st   [LANES];
  logic [BYTE_IDX_W-1:0]   lane_byte [LANES];
  logic [BIT_IDX_W-1:0]    lane_bit  [LANES];
  ecc_status_e             st_d;
  logic [FLIPS_W-1:0]      flips_d;
  logic [LANES-1:0]        en_d;
  logic [LANES*BYTE_IDX_W-1:0] byte_d;
  logic [LANES*BIT_IDX_W-1:0]  bit_d;
  logic [LANES*MASK_W-1:0]     mask_d;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ecc_lane_eval #(.BYTE_IDX_W(BYTE_IDX_W), .BIT_IDX_W(BIT_IDX_W)) u_eval (
      .calc_i  (calc_i[l*CODE_W +: CODE_W]),
      .stored_i(stored_i[l*CODE_W +: CODE_W]),
      .status_o(lane_st[l]),
      .byte_o  (lane_byte[l]),
      .bit_o   (lane_bit[l])
    );
    assign byte_d[l*BYTE_IDX_W +: BYTE_IDX_W] = en_d[l] ? lane_byte[l] : '0;
    assign bit_d[l*BIT_IDX_W +: BIT_IDX_W]    = en_d[l] ? lane_bit[l]  : '0;
    assign mask_d[l*MASK_W +: MASK_W] =
      en_d[l] ? (MASK_W'(1) << lane_bit[l]) : '0;
  end

  ecc_lane_merge #(.LANES(LANES)) u_merge (
    .dual_i   (dual_i),
    .lane_st_i(lane_st),
    .status_o (st_d),
    .flips_o  (flips_d),
    .fix_en_o (en_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      status_o   <= '0;
      flips_o    <= '0;
      fix_en_o   <= '0;
      fix_byte_o <= '0;
      fix_bit_o  <= '0;
      fix_mask_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        status_o   <= st_d;
        flips_o    <= flips_d;
        fix_en_o   <= en_d;
        fix_byte_o <= byte_d;
        fix_bit_o  <= bit_d;
        fix_mask_o <= mask_d;
      end
    end
  end
endmodule

// File: rtl/ecc_syndrome_fix_chk.sv
module ecc_syndrome_fix_chk #(
  parameter int BYTE_IDX_W = 8,
  parameter int BIT_IDX_W  = 3,
  parameter int LANES      = 2,
  localparam int HALF_W    = BYTE_IDX_W + BIT_IDX_W,
  localparam int CODE_W    = 2 * HALF_W,
  localparam int MASK_W    = 1 << BIT_IDX_W,
  localparam int FLIPS_W   = $clog2(LANES + 1)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        valid_i,
  input logic                        dual_i,
  input logic [LANES*CODE_W-1:0]     calc_i,
  input logic [LANES*CODE_W-1:0]     stored_i,
  input logic                        valid_o,
  input logic [1:0]                  status_o,
  input logic [FLIPS_W-1:0]          flips_o,
  input logic [LANES-1:0]            fix_en_o,
  input logic [LANES*BYTE_IDX_W-1:0] fix_byte_o,
  input logic [LANES*BIT_IDX_W-1:0]  fix_bit_o,
  input logic [LANES*MASK_W-1:0]     fix_mask_o
);
  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(status_o) && $stable(fix_en_o));

  assert_code_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dual_i && calc_i[CODE_W-1:0] != '0 && stored_i[CODE_W-1:0] != '0 &&
     $countones(calc_i[CODE_W-1:0] ^ stored_i[CODE_W-1:0]) == 1)
    |=> status_o == 2'd1 && fix_en_o == '0);

  assert_mask_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_en_o[0] |-> $countones(fix_mask_o[MASK_W-1:0]) == 1);

  assert_mask_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fix_en_o[0] |-> fix_mask_o[MASK_W-1:0] == '0);

  assert_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd1 || status_o == 2'd3) |-> flips_o == '0);

  assert_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd0 || status_o == 2'd2) |-> flips_o == FLIPS_W'($countones(fix_en_o)));

  assert_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dual_i) |=> fix_en_o[LANES-1:1] == '0);
endmodule

bind ecc_syndrome_fix ecc_syndrome_fix_chk #(
  .BYTE_IDX_W(BYTE_IDX_W), .BIT_IDX_W(BIT_IDX_W), .LANES(LANES)
) u_chk (.*);

// File: tb/tb_ecc_syndrome_fix.sv
module tb_ecc_syndrome_fix;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        dual_i = 1'b0;
  logic [43:0] calc_i = '0;
  logic [43:0] stored_i = '0;
  logic        valid_o;
  logic [1:0]  status_o;
  logic [1:0]  flips_o;
  logic [1:0]  fix_en_o;
  logic [15:0] fix_byte_o;
  logic [5:0]  fix_bit_o;
  logic [15:0] fix_mask_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  fl;
    logic [1:0]  en;
    logic [15:0] by;
    logic [5:0]  bi;
    logic [15:0] mk;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk_i = ~clk_i;

  ecc_syndrome_fix dut (.*);

  function automatic logic [21:0] fix_syn(input logic [7:0] by, input logic [2:0] bi);
    logic [10:0] p;
    p = {by, bi};
    return {~p, p};
  endfunction

  // lane rule from R2..R5
  function automatic void lane_model(input logic [21:0] c, input logic [21:0] s,
                                     output logic [1:0] st, output logic [7:0] by,
                                     output logic [2:0] bi);
    logic [21:0] y;
    y  = c ^ s;
    by = y[10:3];
    bi = y[2:0];
    if (y == 0 || c == 0 || s == 0) st = 2'd0;
    else if ($countones(y) == 1) st = 2'd1;
    else if ($countones(y) == 11 && ((c[10:0] ^ c[21:11]) ^ (s[10:0] ^ s[21:11])) == 11'h7FF)
      st = 2'd2;
    else st = 2'd3;
  endfunction

  task automatic drive(input logic [43:0] c, input logic [43:0] s, input logic d,
                       input string tag);
    exp_t e;
    logic [1:0] s0, s1;
    logic [7:0] b0, b1;
    logic [2:0] i0, i1;
    lane_model(c[21:0], s[21:0], s0, b0, i0);
    lane_model(c[43:22], s[43:22], s1, b1, i1);
    e = '0;
    if (s0 == 2'd1 || s0 == 2'd3) e.st = s0;
    else if (d && (s1 == 2'd1 || s1 == 2'd3)) begin
      e.st = s1; e.en[0] = (s0 == 2'd2);
    end else begin
      e.en[0] = (s0 == 2'd2);
      e.en[1] = d && (s1 == 2'd2);
      e.fl = 2'(e.en[0]) + 2'(e.en[1]);
      e.st = (e.fl != 0) ? 2'd2 : 2'd0;
    end
    if (e.en[0]) begin e.by[7:0] = b0; e.bi[2:0] = i0; e.mk[7:0] = 8'(1) << i0; end
    if (e.en[1]) begin e.by[15:8] = b1; e.bi[5:3] = i1; e.mk[15:8] = 8'(1) << i1; end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
    calc_i = c; stored_i = s; dual_i = d; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      exp_t a, e;
      string t;
      a = {status_o, flips_o, fix_en_o, fix_byte_o, fix_bit_o, fix_mask_o};
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected", 64'(a), 64'(0));
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a == e, t, 64'(a), 64'(e));
      end
    end
  end

  localparam logic [21:0] CA = 22'h2A_5C3D;
  localparam logic [21:0] CB = 22'h13_9E61;

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check({valid_o, status_o, flips_o, fix_en_o, fix_byte_o, fix_bit_o, fix_mask_o} == '0,
          "R10 reset", 64'({valid_o, status_o, flips_o, fix_en_o}), 64'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);

    drive({22'h0, CA}, {22'h0, CA}, 1'b0, "R2 equal codes");
    drive({22'h0, 22'h0}, {22'h0, CB}, 1'b0, "R2 calc zero");
    drive({22'h0, CA}, {22'h0, 22'h0}, 1'b0, "R2 stored zero");
    drive({22'h0, CA}, {22'h0, CA ^ 22'(1 << 5)}, 1'b0, "R3 single bit lo");
    drive({22'h0, CA}, {22'h0, CA ^ 22'(1 << 21)}, 1'b0, "R3 single bit hi");
    drive({22'h0, CA}, {22'h0, CA ^ fix_syn(8'h00, 3'd0)}, 1'b0, "R4 byte0 bit0");
    drive({22'h0, CB}, {22'h0, CB ^ fix_syn(8'hFF, 3'd7)}, 1'b0, "R4 byte255 bit7");
    drive({22'h0, CA}, {22'h0, CA ^ fix_syn(8'hA5, 3'd3)}, 1'b0, "R4 byte a5 bit3");
    drive({22'h0, CA}, {22'h0, CA ^ 22'h3}, 1'b0, "R5 two bits");
    drive({22'h0, CA}, {22'h0, CA ^ {~11'h001, 11'h002}}, 1'b0, "R5 11 bits pair fails");
    drive({22'h0, CA}, {22'h0, CA ^ fix_syn(8'h12, 3'd1) ^ 22'(1 << 15)}, 1'b0,
          "R5 twelve bits");
    drive({CB, CA}, {CB ^ fix_syn(8'h40, 3'd6), CA ^ fix_syn(8'h07, 3'd2)}, 1'b1,
          "R6 R8 dual two fixes");
    drive({CB, CA}, {CB ^ fix_syn(8'h33, 3'd4), CA}, 1'b1, "R6 R8 dual lane1 fix only");
    drive({CB, CA}, {CB, CA}, 1'b1, "R8 dual clean");
    drive({CB, CA}, {CB ^ fix_syn(8'h01, 3'd1), CA ^ 22'h5}, 1'b1,
          "R7 lane0 fatal masks lane1");
    drive({CB, CA}, {CB ^ 22'(1 << 9), CA ^ fix_syn(8'h80, 3'd5)}, 1'b1,
          "R7 lane0 fix kept lane1 code err");
    drive({CB, CA}, {CB ^ 22'h3, CA}, 1'b1, "R7 lane1 fatal");
    drive({CB, CA}, {CB ^ 22'h3, CA}, 1'b0, "R9 single ignores lane1 fatal");
    drive({CB, CA}, {CB ^ fix_syn(8'h10, 3'd0), CA}, 1'b0, "R9 single ignores lane1 fix");

    // R1 latency and hold
    @(negedge clk_i);
    calc_i = {22'h0, CA}; stored_i = {22'h0, CA ^ fix_syn(8'h5A, 3'd2)}; dual_i = 1'b0;
    valid_i = 1'b1;
    begin
      exp_t e;
      e = '0; e.st = 2'd2; e.fl = 2'd1; e.en = 2'b01; e.by[7:0] = 8'h5A; e.bi[2:0] = 3'd2;
      e.mk[7:0] = 8'h04;
      exp_q.push_back(e); tag_q.push_back("R1 latency");
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    check(valid_o == 1'b1, "R1 strobe after one cycle", 64'(valid_o), 64'(1));
    stored_i = {22'h0, CA ^ 22'h3};
    @(negedge clk_i);
    check(valid_o == 1'b0, "R1 strobe is a pulse", 64'(valid_o), 64'(0));
    check(status_o == 2'd2 && fix_byte_o[7:0] == 8'h5A, "R1 hold without strobe",
          64'({status_o, fix_byte_o}), 64'({2'd2, 16'h005A}));
    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R1 all results seen", 64'(exp_q.size()), 64'(0));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule